// File: doc/BRIEF.md
# Digital Buck PWM Modulator with Soft-Start

This block is the switching core of a voltage-mode synchronous buck controller. A free-running sawtooth counter sets a fixed switching period, picked from two rates by a select pin. At the start of each period the block latches a duty command and asserts the high-side on request for that many clock cycles. A strobe marks the first cycle of every period. The duty range runs from 0% to 100%, both ends included.

A soft-start sequencer shapes start-up. While the block is enabled, a soft-start code rises by one every `SS_STEP` clocks. The regulation target is the smaller of that code and a fixed reference code. A feedback code from an external converter is compared with this target at each period start. When feedback lies above the target, that period carries no pulse, so the output voltage can climb no faster than the ramp. The sequencer has three states. `ST_IDLE` holds the code at zero. `ST_RAMP` raises it. `ST_DONE` is entered once the code passes the reference. Its transitions are: `ST_IDLE -> ST_RAMP` on enable; `ST_RAMP -> ST_DONE` when the code steps from the reference value to one above it; `ST_RAMP -> ST_IDLE` and `ST_DONE -> ST_IDLE` when enable drops.

The defaults assume a 96 MHz clock: 320 counts per period at the low rate, 160 at the high rate, a reference code of 512 and a 600-clock step. This gives roughly 3.2 ms of ramp.

Top module: `buck_dpwm`

## Requirements
- R1: While reset is held, `pwm_on` and `ss_done` are 0 and `period_start` is 1, because the counter sits at zero.
- R2: With `rate_sel`=0 a period lasts `PER_LO` clocks, and with `rate_sel`=1 it lasts `PER_HI` clocks. `rate_sel` is sampled on the last cycle of each period. `period_start` is high only on the first cycle of each period.
- R3: In an active, unclamped period, `pwm_on` is high for the first min(`cmd`, period) cycles, counted from the strobe cycle. A `cmd` of 0 gives no pulse, and a `cmd` at or above the period length keeps `pwm_on` high for the whole period.
- R4: `cmd` is captured only on the clock edge that begins a period. A change to `cmd` inside a period does not alter that period's pulse.
- R5: After enable is first seen high in `ST_IDLE`, `ss_done` rises exactly (`REF_CODE`+1)×`SS_STEP` clock edges later. The soft-start code never decreases while ramping.
- R6: A period's pulse is suppressed (width 0) when `fb` is above min(`REF_CODE`, soft-start code) at the capture edge. `fb` equal to the target does not suppress it.
- R7: Dropping `en` forces `pwm_on` low in the same cycle. On the next edge the soft-start code returns to zero and `ss_done` clears. Periods captured while disabled carry no pulse, and a later enable replays the full ramp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | 0 selects the low switching rate, 1 the high rate |
| en | input | 1 | Converter enable; low clears soft-start and blocks pulses |
| cmd | input | CMD_W | Duty command in clock cycles |
| fb | input | FB_W | Feedback code compared with the soft-start-limited target |
| pwm_on | output | 1 | High-side on request |
| period_start | output | 1 | High on the first cycle of each switching period |
| ss_done | output | 1 | Soft-start code has passed the reference |

## Verification
Several properties are checked on every cycle: the counter stays inside the current period, strobes never appear back to back, and the latched duty only moves at a period boundary. The same holds for these: the soft-start code only grows while ramping, `ss_done` implies the code is above the reference, a clamped capture yields a silent first cycle, and disable clears the sequencer one edge later. Only the bench scenarios can show the measured pulse widths across the command range and the exact period lengths at both rates. They also show that a mid-period command change leaves the pulse alone, the exact cycle on which `ss_done` rises, and the replay of the ramp after re-enable.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_DONE = 2'd2
    } ss_state_e;
endpackage

// File: rtl/dpwm_sawtooth.sv
`timescale 1ns/1ps
// Free-running period counter; the rate pick is applied at each period boundary.
module dpwm_sawtooth #(
    parameter int PER_LO = 320,
    parameter int PER_HI = 160,
    parameter int CNT_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             strobe
);
    logic [CNT_W-1:0] per_q;

    assign wrap   = (cnt == per_q - 1'b1);
    assign strobe = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            per_q <= CNT_W'(PER_LO);
        end else if (wrap) begin
            cnt   <= '0;
            per_q <= rate_sel ? CNT_W'(PER_HI) : CNT_W'(PER_LO);
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per_q); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R2
endmodule

// File: rtl/dpwm_softstart.sv
`timescale 1ns/1ps
// Soft-start sequencer: linear code ramp, limited target output.
module dpwm_softstart
    import dpwm_pkg::*;
#(
    parameter int REF_CODE = 512,
    parameter int SS_STEP  = 600,
    parameter int SS_W     = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic [SS_W-1:0] target,
    output logic            active,
    output logic            done
);
    localparam int STEP_W = (SS_STEP > 1) ? $clog2(SS_STEP) : 1;

    ss_state_e         state_q, state_n;
    logic [STEP_W-1:0] step_q;
    logic [SS_W-1:0]   code_q;
    logic              step_last;

    assign step_last = (step_q == STEP_W'(SS_STEP - 1));

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_n = ST_RAMP;
            ST_RAMP: begin
                if (!en)
                    state_n = ST_IDLE;
                else if (step_last && code_q == SS_W'(REF_CODE))
                    state_n = ST_DONE;
            end
            ST_DONE: if (!en) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // ramp datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            code_q <= '0;
        end else begin
            unique case (state_q)
                ST_RAMP: begin
                    if (!en) begin
                        step_q <= '0;
                        code_q <= '0;
                    end else if (step_last) begin
                        step_q <= '0;
                        code_q <= code_q + 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!en) begin
                        step_q <= '0;
                        code_q <= '0;
                    end
                end
                default: begin
                    step_q <= '0;
                    code_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        done   = (state_q == ST_DONE);
        active = (state_q != ST_IDLE);
        target = (code_q < SS_W'(REF_CODE)) ? code_q : SS_W'(REF_CODE);
    end

    AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && en) |=> (code_q >= $past(code_q))); // R5
    AST_DONE_ABOVE_REF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (code_q > SS_W'(REF_CODE))); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (code_q == '0 && !done)); // R7
endmodule

// File: rtl/dpwm_compare.sv
`timescale 1ns/1ps
// Duty capture at the period boundary and counter compare.
module dpwm_compare #(
    parameter int CMD_W = 9,
    parameter int CNT_W = 9,
    parameter int SS_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             active,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CMD_W-1:0] cmd,
    input  logic [SS_W-1:0]  fb,
    input  logic [SS_W-1:0]  target,
    output logic             pwm
);
    localparam int CMP_W = (CMD_W > CNT_W) ? CMD_W : CNT_W;

    logic [CMD_W-1:0] duty_q;
    logic             clamp;

    assign clamp = (fb > target);

    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_q <= '0;
        else if (wrap)
            duty_q <= (en && active && !clamp) ? cmd : '0;
    end

    assign pwm = en && (CMP_W'(cnt) < CMP_W'(duty_q));

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_q)); // R4
    AST_CLAMP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && clamp) |=> !pwm); // R6
endmodule

// File: rtl/buck_dpwm.sv
`timescale 1ns/1ps
module buck_dpwm #(
    parameter int PER_LO   = 320,
    parameter int PER_HI   = 160,
    parameter int CMD_W    = 9,
    parameter int REF_CODE = 512,
    parameter int SS_STEP  = 600,
    localparam int FB_W    = $clog2(REF_CODE + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_sel,
    input  logic             en,
    input  logic [CMD_W-1:0] cmd,
    input  logic [FB_W-1:0]  fb,
    output logic             pwm_on,
    output logic             period_start,
    output logic             ss_done
);
    localparam int PER_MAX = (PER_LO > PER_HI) ? PER_LO : PER_HI;
    localparam int CNT_W   = $clog2(PER_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [FB_W-1:0]  target;
    logic             active;

    dpwm_sawtooth #(
        .PER_LO(PER_LO), .PER_HI(PER_HI), .CNT_W(CNT_W)
    ) u_saw (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .cnt(cnt), .wrap(wrap), .strobe(period_start)
    );

    dpwm_softstart #(
        .REF_CODE(REF_CODE), .SS_STEP(SS_STEP), .SS_W(FB_W)
    ) u_ss (
        .clk(clk), .rst_n(rst_n), .en(en),
        .target(target), .active(active), .done(ss_done)
    );

    dpwm_compare #(
        .CMD_W(CMD_W), .CNT_W(CNT_W), .SS_W(FB_W)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .active(active), .wrap(wrap),
        .cnt(cnt), .cmd(cmd), .fb(fb), .target(target), .pwm(pwm_on)
    );

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_on); // R7
endmodule

// File: tb/buck_dpwm_tb.sv
`timescale 1ns/1ps
module buck_dpwm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PER_LO   = 20;
    localparam int PER_HI   = 10;
    localparam int CMD_W    = 6;
    localparam int REF_CODE = 20;
    localparam int SS_STEP  = 4;
    localparam int FB_W     = $clog2(REF_CODE + 2);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rate_sel;
    logic             en;
    logic [CMD_W-1:0] cmd;
    logic [FB_W-1:0]  fb;
    logic             pwm_on, period_start, ss_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    typedef struct { int width; string tag; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_dpwm #(
        .PER_LO(PER_LO), .PER_HI(PER_HI), .CMD_W(CMD_W),
        .REF_CODE(REF_CODE), .SS_STEP(SS_STEP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .en(en),
        .cmd(cmd), .fb(fb), .pwm_on(pwm_on),
        .period_start(period_start), .ss_done(ss_done)
    );

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // monitor: measures pulse width of each period for which an item is queued
    bit   meas_on = 1'b0;
    int   meas_cnt = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (rst_n && period_start) begin
            if (meas_on) begin
                chk(meas_cnt == cur.width, cur.tag, meas_cnt, cur.width);
                meas_on = 1'b0;
            end
            if (exp_q.size() > 0) begin
                cur = exp_q.pop_front();
                meas_on = 1'b1;
                meas_cnt = 0;
            end
        end
        if (meas_on && pwm_on) meas_cnt++;
    end

    // driver: set inputs in one period, expect the width of the next
    task automatic period_check(int c, int f, int w, string tag);
        @(negedge clk iff period_start);
        #2;
        cmd = CMD_W'(c);
        fb  = FB_W'(f);
        exp_q.push_back('{w, tag});
        @(negedge clk iff period_start);
    endtask

    task automatic measure_period(int expv, string tag);
        int n;
        @(negedge clk iff period_start);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!period_start);
        chk(n == expv, tag, n, expv);
    endtask

    task automatic drain();
        @(negedge clk iff period_start);
        @(negedge clk iff period_start);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rate_sel = 1'b0; en = 1'b0; cmd = '0; fb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pwm_on == 1'b0, "R1 pwm in reset", int'(pwm_on), 0);
        chk(ss_done == 1'b0, "R1 done in reset", int'(ss_done), 0);
        chk(period_start == 1'b1, "R1 strobe in reset", int'(period_start), 1);
        rst_n = 1'b1;

        measure_period(PER_LO, "R2 low rate period");

        // start-up with feedback at the reference: clamped during the ramp
        en = 1'b1; cmd = 6'd10; fb = FB_W'(REF_CODE);
        period_check(10, REF_CODE, 0, "R6 clamp while ramping");
        @(posedge ss_done);
        period_check(10, REF_CODE, 10, "R6 fb equal to target passes");
        period_check(10, REF_CODE + 1, 0, "R6 fb above reference");

        // duty patterns
        period_check(0, 0, 0, "R3 zero command");
        period_check(7, 0, 7, "R3 partial duty");
        period_check(19, 0, 19, "R3 one short of full");
        period_check(PER_LO, 0, PER_LO, "R3 command equals period");
        period_check(63, 0, PER_LO, "R3 full-scale command");

        // mid-period command change
        period_check(12, 0, 12, "R4 mid-period change ignored");
        repeat (3) @(negedge clk);
        cmd = 6'd3;
        drain();

        // high rate
        rate_sel = 1'b1;
        measure_period(PER_HI, "R2 transition period");
        measure_period(PER_HI, "R2 high rate period");
        period_check(63, 0, PER_HI, "R3 full duty at high rate");
        period_check(4, 0, 4, "R3 partial duty at high rate");
        drain();

        // disable behaviour
        cmd = 6'd63;
        drain();
        @(negedge clk);
        chk(pwm_on == 1'b1, "R3 full duty before disable", int'(pwm_on), 1);
        en = 1'b0;
        #1;
        chk(pwm_on == 1'b0, "R7 immediate off", int'(pwm_on), 0);
        @(posedge clk); #1;
        chk(ss_done == 1'b0, "R7 done cleared", int'(ss_done), 0);
        period_check(63, 0, 0, "R7 no pulse while disabled");
        drain();

        // re-enable: ramp replays with exact timing
        @(negedge clk);
        en = 1'b1;
        repeat ((REF_CODE + 1) * SS_STEP) @(posedge clk);
        #1;
        chk(ss_done == 1'b0, "R5 done not yet", int'(ss_done), 0);
        @(posedge clk); #1;
        chk(ss_done == 1'b1, "R5 done rises on time", int'(ss_done), 1);
        period_check(5, 0, 5, "R7 pulses resume after replay");
        drain();

        finish_run();
    end
endmodule